// File: doc/BRIEF.md
# Serial Bus Controller Status Register

This block holds the eight status flags of a byte-level serial bus protocol controller and combines them, through per-flag mask bits, into one interrupt request. Event strobes arrive from the transmit and receive state machines and from the error register. Access strobes arrive from the CPU or DMA side: a write to the opcode register, a read of the receive data register, and a write to the status register. Every flag is registered, so an event shows in the status byte one clock after the cycle in which it is presented.

The transmit-ready flag tracks one queued opcode and whether that opcode is meant for the frame now on the bus or for the following frame. A break cancels the queued opcode whatever its frame. A bit-timing, framing or CRC error, or lost arbitration, cancels the opcode only when it belongs to the current frame. A frame-boundary strobe promotes a next-frame opcode to the current frame. Two control inputs gate the whole register. Disable forces the register to its reset value. A cleared enable resets every flag except the idle flag.

Top module: `sbc_status`

## Requirements
- R1: After reset the status byte is 0x40. Bit positions from bit 7 down to bit 0 are: error summary, transmit ready, receive full, arbitration lost, receive-data-toggle, end-of-data, end-of-frame, idle.
- R2: While `disBit` is 1, the status byte is held at 0x40 whatever the other inputs do.
- R3: While `enBit` is 0 and `disBit` is 0, bits 7..1 are held at their reset values (bit 6 = 1, others 0), bit 0 follows `idleIn`, and any queued opcode is dropped.
- R4: Bit 7 equals the OR of all bits of `errBits` sampled in the previous cycle.
- R5: A write to the opcode register (`opWrite`) clears bit 6. Bit 6 sets again when `opAccept` pulses.
- R6: An opcode rejected as illegal (`opReject`) sets bit 6 at once.
- R7: `evtBreak` sets bit 6 and drops the queued opcode, whether that opcode is for the current frame or the next one.
- R8: `evtFrameErr` sets bit 6 and drops the opcode when the opcode belongs to the current frame (`opForNext` was 0 at the write, or a `frameDone` pulse has happened since). When the opcode belongs to the next frame, the opcode is kept and bit 6 stays 0.
- R9: `evtArbLost` sets bit 4. It changes bit 6 under the same frame rule as R8.
- R10: `rxByteDone` sets bit 5 and `rxRead` clears it. When both occur in the same cycle, bit 5 is set.
- R11: A status write with bit 4 of `statusWdata` at 0 clears bit 4. A write with that bit at 1 leaves bit 4 unchanged. `evtArbLost` in the same cycle as a clearing write leaves bit 4 set.
- R12: Bits 3..0 follow `rdtIn`, `eodmIn`, `eofmIn` and `idleIn` with one cycle of delay.
- R13: `irq` is the OR over all eight bits of (status bit AND the `intMask` bit at the same position).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enBit | input | 1 | Controller enable control bit |
| disBit | input | 1 | Controller disable control bit |
| opWrite | input | 1 | Opcode register written (CPU or DMA) |
| opForNext | input | 1 | With opWrite: opcode scheduled for the next frame |
| opAccept | input | 1 | Transmit state machine accepted the queued opcode |
| opReject | input | 1 | Written opcode rejected as illegal |
| evtBreak | input | 1 | Break received |
| evtFrameErr | input | 1 | Bit-timing, framing or CRC error |
| evtArbLost | input | 1 | Transmitter lost arbitration |
| frameDone | input | 1 | Frame boundary; next-frame opcode becomes current |
| rxByteDone | input | 1 | Byte moved from shift register to receive data register |
| rxRead | input | 1 | Receive data register read (CPU or DMA) |
| errBits | input | ERR_W | Error register contents |
| statusWrite | input | 1 | Status register write strobe |
| statusWdata | input | 8 | Status write data (only bit 4 acts) |
| rdtIn | input | 1 | Receive-data-toggle level |
| eodmIn | input | 1 | End-of-data level |
| eofmIn | input | 1 | End-of-frame level |
| idleIn | input | 1 | Bus idle level |
| intMask | input | 8 | Per-flag interrupt mask, same bit positions as status |
| status | output | 8 | Status byte |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `opWrite` never arrives in the same cycle as `opAccept`, `opReject`, `evtBreak`, `evtFrameErr`, `evtArbLost` or `frameDone`. They also assume that `opReject` and `opAccept` only arrive while an opcode is queued. The bench keeps to this by driving each transmit-side strobe as a lone one-cycle pulse on its own falling edge, with the opcode write always in an earlier cycle than its response. Same-cycle priority is tested only where R10 and R11 define it: a set against a clear of the same flag.

// File: rtl/sbc_status_pkg.sv
package sbc_status_pkg;
  localparam int STATUS_W  = 8;
  localparam int FOLLOW_W  = 4;
  localparam int ERR_BIT   = 7;
  localparam int TRDY_BIT  = 6;
  localparam int RDRF_BIT  = 5;
  localparam int TLA_BIT   = 4;
  localparam int IDLE_BIT  = 0;
  localparam logic [STATUS_W-1:0] STATUS_RESET = 8'h40;

  // strobes from control to datapath
  typedef struct packed {
    logic holdAll;   // disable: whole register to reset
    logic holdLow;   // not enabled: all but idle to reset
    logic trdySet;
    logic trdyClr;
    logic rdrfSet;
    logic rdrfClr;
    logic tlaSet;
    logic tlaClr;
  } strobe_t;
endpackage

// File: rtl/sbc_status_ctrl.sv
module sbc_status_ctrl
  import sbc_status_pkg::*;
#(
  parameter int ERR_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enBit,
  input  logic             disBit,
  input  logic             opWrite,
  input  logic             opForNext,
  input  logic             opAccept,
  input  logic             opReject,
  input  logic             evtBreak,
  input  logic             evtFrameErr,
  input  logic             evtArbLost,
  input  logic             frameDone,
  input  logic             rxByteDone,
  input  logic             rxRead,
  input  logic [ERR_W-1:0] errBits,
  input  logic             statusWrite,
  input  logic [STATUS_W-1:0] statusWdata,
  output strobe_t          strb,
  output logic             errAny,
  output logic             pendValid
);
  logic enabled;
  logic pendNext;
  logic cancelCur;
  logic dropPend;

  assign enabled   = enBit && !disBit;
  // errors that cancel only an opcode meant for this frame
  assign cancelCur = (evtFrameErr || evtArbLost) && pendValid && !pendNext;
  assign dropPend  = opAccept || opReject || evtBreak || cancelCur;
  assign errAny    = |errBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendNext  <= 1'b0;
    end else if (!enabled) begin
      pendValid <= 1'b0;
      pendNext  <= 1'b0;
    end else if (opWrite) begin
      pendValid <= 1'b1;
      pendNext  <= opForNext;
    end else if (dropPend) begin
      pendValid <= 1'b0;
      pendNext  <= 1'b0;
    end else if (frameDone) begin
      pendNext  <= 1'b0;
    end
  end

  always_comb begin
    strb.holdAll = disBit;
    strb.holdLow = !enBit;
    strb.trdySet = dropPend;
    strb.trdyClr = opWrite;
    strb.rdrfSet = rxByteDone;
    strb.rdrfClr = rxRead;
    strb.tlaSet  = evtArbLost;
    strb.tlaClr  = statusWrite && !statusWdata[TLA_BIT];
  end

  // R7: a break always drops the queued opcode
  a_r7_break_drops: assert property (@(posedge clk) disable iff (!rstN)
    (evtBreak && enabled && !opWrite) |=> !pendValid);
  // R8: a next-frame opcode survives a frame error
  a_r8_next_kept: assert property (@(posedge clk) disable iff (!rstN)
    (evtFrameErr && pendValid && pendNext && enabled && !opWrite &&
     !opAccept && !opReject && !evtBreak) |=> pendValid);
endmodule

// File: rtl/sbc_status_dp.sv
module sbc_status_dp
  import sbc_status_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic                errAny,
  input  logic [FOLLOW_W-1:0] followIn,
  input  logic [STATUS_W-1:0] intMask,
  output logic [STATUS_W-1:0] status,
  output logic                irq
);
  logic                errQ, trdyQ, rdrfQ, tlaQ;
  logic [FOLLOW_W-1:0] followQ;
  logic [STATUS_W-1:0] masked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ  <= STATUS_RESET[ERR_BIT];
      trdyQ <= STATUS_RESET[TRDY_BIT];
      rdrfQ <= STATUS_RESET[RDRF_BIT];
      tlaQ  <= STATUS_RESET[TLA_BIT];
    end else if (strb.holdAll || strb.holdLow) begin
      errQ  <= STATUS_RESET[ERR_BIT];
      trdyQ <= STATUS_RESET[TRDY_BIT];
      rdrfQ <= STATUS_RESET[RDRF_BIT];
      tlaQ  <= STATUS_RESET[TLA_BIT];
    end else begin
      errQ <= errAny;
      if (strb.trdySet)      trdyQ <= 1'b1;
      else if (strb.trdyClr) trdyQ <= 1'b0;
      if (strb.rdrfSet)      rdrfQ <= 1'b1;
      else if (strb.rdrfClr) rdrfQ <= 1'b0;
      if (strb.tlaSet)       tlaQ  <= 1'b1;
      else if (strb.tlaClr)  tlaQ  <= 1'b0;
    end
  end

  for (genvar i = 0; i < FOLLOW_W; i++) begin : g_follow
    localparam bit KEEP_WHEN_OFF = (i == IDLE_BIT);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        followQ[i] <= STATUS_RESET[i];
      else if (strb.holdAll || (strb.holdLow && !KEEP_WHEN_OFF))
        followQ[i] <= STATUS_RESET[i];
      else
        followQ[i] <= followIn[i];
    end
  end

  assign status = {errQ, trdyQ, rdrfQ, tlaQ, followQ};

  for (genvar b = 0; b < STATUS_W; b++) begin : g_mask
    assign masked[b] = status[b] & intMask[b];
  end
  assign irq = |masked;

  // R2: disable forces the reset value
  a_r2_disable_reset: assert property (@(posedge clk) disable iff (!rstN)
    strb.holdAll |=> (status == STATUS_RESET));
  // R10: a received byte wins over a read in the same cycle
  a_r10_rdrf_set: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdrfSet && !strb.holdAll && !strb.holdLow) |=> status[RDRF_BIT]);
endmodule

// File: rtl/sbc_status.sv
module sbc_status
  import sbc_status_pkg::*;
#(
  parameter int ERR_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enBit,
  input  logic             disBit,
  input  logic             opWrite,
  input  logic             opForNext,
  input  logic             opAccept,
  input  logic             opReject,
  input  logic             evtBreak,
  input  logic             evtFrameErr,
  input  logic             evtArbLost,
  input  logic             frameDone,
  input  logic             rxByteDone,
  input  logic             rxRead,
  input  logic [ERR_W-1:0] errBits,
  input  logic             statusWrite,
  input  logic [7:0]       statusWdata,
  input  logic             rdtIn,
  input  logic             eodmIn,
  input  logic             eofmIn,
  input  logic             idleIn,
  input  logic [7:0]       intMask,
  output logic [7:0]       status,
  output logic             irq
);
  strobe_t strb;
  logic    errAny;
  logic    pendValid;
  logic    enabled;

  assign enabled = enBit && !disBit;

  sbc_status_ctrl #(.ERR_W(ERR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enBit(enBit), .disBit(disBit),
    .opWrite(opWrite), .opForNext(opForNext), .opAccept(opAccept),
    .opReject(opReject), .evtBreak(evtBreak), .evtFrameErr(evtFrameErr),
    .evtArbLost(evtArbLost), .frameDone(frameDone),
    .rxByteDone(rxByteDone), .rxRead(rxRead), .errBits(errBits),
    .statusWrite(statusWrite), .statusWdata(statusWdata),
    .strb(strb), .errAny(errAny), .pendValid(pendValid)
  );

  sbc_status_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .errAny(errAny),
    .followIn({rdtIn, eodmIn, eofmIn, idleIn}),
    .intMask(intMask), .status(status), .irq(irq)
  );

  // R3: not enabled keeps bits 7..1 at reset
  a_r3_off_low: assert property (@(posedge clk) disable iff (!rstN)
    (!enBit && !disBit) |=> (status[7:1] == STATUS_RESET[7:1]));
  // R4: error summary follows the error register
  a_r4_err_or: assert property (@(posedge clk) disable iff (!rstN)
    enabled |=> (status[ERR_BIT] == |$past(errBits)));
  // R5: opcode write drops transmit ready
  a_r5_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    (opWrite && enabled) |=> !status[TRDY_BIT]);
  // R6: rejected opcode raises transmit ready
  a_r6_reject_sets: assert property (@(posedge clk) disable iff (!rstN)
    (opReject && enabled && !opWrite) |=> status[TRDY_BIT]);
  // R11: writing one to the lost-arbitration bit leaves it alone
  a_r11_tla_keep: assert property (@(posedge clk) disable iff (!rstN)
    (statusWrite && statusWdata[TLA_BIT] && !evtArbLost && enabled)
      |=> (status[TLA_BIT] == $past(status[TLA_BIT])));
  // transmit ready mirrors the absence of a queued opcode
  a_r5_trdy_pend: assert property (@(posedge clk) disable iff (!rstN)
    enabled |=> (status[TRDY_BIT] == !pendValid));
endmodule

// File: tb/sbc_status_bench.sv
module sbc_status_bench;
  localparam int ERR_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enBit = 0, disBit = 0, opWrite = 0, opForNext = 0, opAccept = 0;
  logic opReject = 0, evtBreak = 0, evtFrameErr = 0, evtArbLost = 0;
  logic frameDone = 0, rxByteDone = 0, rxRead = 0, statusWrite = 0;
  logic [ERR_W-1:0] errBits = '0;
  logic [7:0] statusWdata = 8'h00;
  logic rdtIn = 0, eodmIn = 0, eofmIn = 0, idleIn = 0;
  logic [7:0] intMask = 8'h00;
  logic [7:0] status;
  logic irq;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sbc_status #(.ERR_W(ERR_W)) u_sbc_status (
    .clk(clk), .rstN(rstN), .enBit(enBit), .disBit(disBit),
    .opWrite(opWrite), .opForNext(opForNext), .opAccept(opAccept),
    .opReject(opReject), .evtBreak(evtBreak), .evtFrameErr(evtFrameErr),
    .evtArbLost(evtArbLost), .frameDone(frameDone),
    .rxByteDone(rxByteDone), .rxRead(rxRead), .errBits(errBits),
    .statusWrite(statusWrite), .statusWdata(statusWdata),
    .rdtIn(rdtIn), .eodmIn(eodmIn), .eofmIn(eofmIn), .idleIn(idleIn),
    .intMask(intMask), .status(status), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: pulses driven now are seen at the next rising edge
  task automatic step();
    @(negedge clk);
    opWrite = 0; opAccept = 0; opReject = 0; evtBreak = 0;
    evtFrameErr = 0; evtArbLost = 0; frameDone = 0;
    rxByteDone = 0; rxRead = 0; statusWrite = 0;
  endtask

  task automatic writeOp(input logic nxt);
    opWrite = 1; opForNext = nxt; step();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !finished) begin
        nFail++;
        $display("FAIL watchdog: got %0d expected %0d", cycles, 20000);
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
        $finish;
      end
    end
  end

  initial begin
    step(); step();
    rstN = 1;
    step();
    chk("R1 reset value", status, 8'h40);

    // R2: disable holds reset even with active inputs
    enBit = 1; disBit = 1; idleIn = 1; errBits = 6'd3; rdtIn = 1;
    rxByteDone = 1; step();
    chk("R2 disable hold", status, 8'h40);
    disBit = 0; step();
    chk("R4 err with enable", status, 8'hC9);

    // R3: enable low keeps only idle
    enBit = 0; step();
    chk("R3 enable low", status, 8'h41);
    enBit = 1; idleIn = 0; rdtIn = 0; errBits = '0; step();
    chk("R3 re-enable", status, 8'h40);

    // R12: sweep follower levels
    for (int v = 0; v < 16; v++) begin
      {rdtIn, eodmIn, eofmIn, idleIn} = v[3:0];
      step();
      chk("R12 follow", status, 8'h40 | 8'(v));
    end
    {rdtIn, eodmIn, eofmIn, idleIn} = 4'b0; step();

    // R4: sweep error register
    for (int e = 0; e < (1 << ERR_W); e++) begin
      errBits = e[ERR_W-1:0];
      step();
      chk("R4 err or", status, (e != 0) ? 8'hC0 : 8'h40);
    end
    errBits = '0; step();

    // R5: write then accept
    writeOp(0);
    chk("R5 write clears", status, 8'h00);
    step();
    chk("R5 held while queued", status, 8'h00);
    opAccept = 1; step();
    chk("R5 accept sets", status, 8'h40);

    // R6: reject
    writeOp(0);
    chk("R6 write clears", status, 8'h00);
    opReject = 1; step();
    chk("R6 reject sets", status, 8'h40);

    // R7: break for both frame tags
    for (int nx = 0; nx < 2; nx++) begin
      writeOp(nx[0]);
      chk("R7 queued", status, 8'h00);
      evtBreak = 1; step();
      chk("R7 break sets", status, 8'h40);
    end

    // R8: frame error vs frame tag
    writeOp(0);
    evtFrameErr = 1; step();
    chk("R8 this-frame cancelled", status, 8'h40);
    writeOp(1);
    evtFrameErr = 1; step();
    chk("R8 next-frame kept", status, 8'h00);
    frameDone = 1; step();
    chk("R8 promoted", status, 8'h00);
    evtFrameErr = 1; step();
    chk("R8 promoted cancelled", status, 8'h40);

    // R9: lost arbitration
    writeOp(0);
    evtArbLost = 1; step();
    chk("R9 this-frame arb", status, 8'h50);
    statusWrite = 1; statusWdata = 8'h00; step();
    chk("R11 clear by zero", status, 8'h40);
    writeOp(1);
    evtArbLost = 1; step();
    chk("R9 next-frame arb", status, 8'h10);
    opAccept = 1; step();
    chk("R9 accept after arb", status, 8'h50);

    // R11: writing one and same-cycle set
    statusWrite = 1; statusWdata = 8'hFF; step();
    chk("R11 write one no effect", status, 8'h50);
    statusWrite = 1; statusWdata = 8'hEF; evtArbLost = 1; step();
    chk("R11 set wins", status, 8'h50);
    statusWrite = 1; statusWdata = 8'hEF; step();
    chk("R11 cleared", status, 8'h40);

    // R10: receive full
    rxByteDone = 1; step();
    chk("R10 byte sets", status, 8'h60);
    step();
    chk("R10 held", status, 8'h60);
    rxRead = 1; step();
    chk("R10 read clears", status, 8'h40);
    rxByteDone = 1; rxRead = 1; step();
    chk("R10 set wins", status, 8'h60);
    rxRead = 1; step();
    chk("R10 cleared", status, 8'h40);

    // R3: enable low drops flags and queued opcode
    rxByteDone = 1; evtArbLost = 1; step();
    writeOp(0);
    chk("R3 before drop", status, 8'h30);
    enBit = 0; step();
    chk("R3 flags dropped", status, 8'h40);
    enBit = 1; step();
    chk("R3 opcode dropped", status, 8'h40);

    // R13: mask sweep over a known status 0xF5
    errBits = 6'd1; rxByteDone = 1; evtArbLost = 1;
    eodmIn = 1; idleIn = 1; step();
    chk("R13 setup", status, 8'hF5);
    for (int m = 0; m < 256; m++) begin
      intMask = m[7:0];
      #1;
      chk("R13 irq", {7'b0, irq}, {7'b0, |(8'hF5 & m[7:0])});
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule